// File: doc/BRIEF.md
# Calibrated ADC Output Code Formatter

This block takes the signed result of a conversion filter and produces the final 16-bit output word. It first subtracts an offset coefficient, then multiplies the difference by an unsigned gain coefficient. It rounds the product, adds a mid-scale offset if bipolar coding is selected, and clamps the result to the output range. The offset and gain coefficients come from a calibration register file. Both codings use the same pair of coefficients, so changing the coding never needs a new calibration.

The coding-select input is not latched by the host. The block samples it on one fixed count of an external conversion-cycle counter, placed a set number of cycles before the word is released. Changes to the select input at any other time do not affect the next word. The finished word is held at the output and is marked by a one-cycle valid strobe, two cycles after the raw-result strobe. The serial port picks it up from there.

Top module: `adc_word_fmt`

## Requirements
- R1: While reset is asserted, and until the first result, `word_out` is 0000h and `word_vld` is low.
- R2: A one-cycle pulse on `raw_vld` in cycle n gives exactly one one-cycle pulse on `word_vld`, in cycle n+2.
- R3: With unipolar coding, the word is the signed product (raw − offset) × gain divided by 2^S and rounded to nearest, with halves rounded toward +∞. Here S = GAIN_FRAC + RAW_W − 1 − OUT_W, which is 22 with the default parameters.
- R4: With unipolar coding, a rounded value above FFFFh gives FFFFh and a value below zero gives 0000h.
- R5: With bipolar coding, the word is the same product divided by 2^(S+1), rounded as in R3, plus 8000h. A zero difference gives 8000h, and negative differences use the same slope as positive ones.
- R6: With bipolar coding, a result above FFFFh after the 8000h offset gives FFFFh, and a result below zero gives 0000h.
- R7: The coding can change from one conversion to the next while the offset and gain inputs stay the same. Each word follows the coding selected for its own conversion.
- R8: `code_bip` (1 = bipolar, 0 = unipolar) is captured only at the clock edge that ends the cycle in which `cyc_cnt` equals CONV_LEN − MODE_LEAD. The value of `code_bip` in any other cycle has no effect on the word.
- R9: `word_out` keeps its value between `word_vld` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_vld | input | 1 | Raw filter result is present this cycle |
| raw_data | input | RAW_W | Signed raw filter result |
| ofs_coef | input | RAW_W | Signed offset coefficient |
| gain_coef | input | GAIN_W | Unsigned gain coefficient with GAIN_FRAC fraction bits |
| code_bip | input | 1 | Coding select: 1 bipolar, 0 unipolar |
| cyc_cnt | input | CYC_W | Cycle count within the current conversion |
| word_out | output | OUT_W | Formatted output word |
| word_vld | output | 1 | One-cycle strobe marking a new word |

## Verification
The bench keeps the default data widths: a 24-bit raw input, a Q1.15 gain and a 16-bit word. These make the scale shift exactly 22, so one-half-LSB rounding points can be reached with small, exact differences. It shortens the conversion to CONV_LEN = 40 and MODE_LEAD = 6, which puts the capture cycle at count 34. That lets every conversion drive the opposite coding on all 41 other cycles and still finish hundreds of conversions quickly. With these values the bench can reach both saturation limits in both codings, the exact mid-scale code, and half-LSB ties of both signs.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  typedef enum logic {
    CODE_UNI = 1'b0,
    CODE_BIP = 1'b1
  } code_mode_e;

endpackage

// File: rtl/fmt_mode_sampler.sv
module fmt_mode_sampler
  import adc_fmt_pkg::*;
#(
  parameter int CYC_W   = 11,
  parameter int SAMP_AT = 1542
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYC_W-1:0] cyc_cnt,
  input  logic             code_bip,
  output code_mode_e       mode_q,
  output logic             samp_hit
);

  localparam logic [CYC_W-1:0] SAMP_CNT = CYC_W'(SAMP_AT);

  assign samp_hit = (cyc_cnt == SAMP_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CODE_UNI;
    end else if (samp_hit) begin
      mode_q <= code_bip ? CODE_BIP : CODE_UNI;
    end
  end

endmodule

// File: rtl/fmt_scale_stage.sv
module fmt_scale_stage
  import adc_fmt_pkg::*;
#(
  parameter int RAW_W  = 24,
  parameter int GAIN_W = 16,
  parameter int PW     = RAW_W + GAIN_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [RAW_W-1:0]     raw,
  input  logic [RAW_W-1:0]     ofs,
  input  logic [GAIN_W-1:0]    gain,
  input  code_mode_e           in_mode,
  output logic                 out_vld,
  output logic signed [PW-1:0] out_prod,
  output code_mode_e           out_mode
);

  // Offset removal widens by one bit; the gain is zero-extended to keep it positive.
  function automatic logic signed [PW-1:0] scale_prod(
    input logic [RAW_W-1:0]  r,
    input logic [RAW_W-1:0]  o,
    input logic [GAIN_W-1:0] g
  );
    logic signed [RAW_W:0]  diff;
    logic signed [GAIN_W:0] gs;
    diff = $signed({r[RAW_W-1], r}) - $signed({o[RAW_W-1], o});
    gs   = $signed({1'b0, g});
    return PW'(diff) * PW'(gs);
  endfunction

  logic signed [PW-1:0] prod_c;
  assign prod_c = scale_prod(raw, ofs, gain);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_prod <= '0;
      out_mode <= CODE_UNI;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_prod <= prod_c;
        out_mode <= in_mode;
      end
    end
  end

endmodule

// File: rtl/fmt_code_stage.sv
module fmt_code_stage
  import adc_fmt_pkg::*;
#(
  parameter int PW    = 42,
  parameter int OUT_W = 16,
  parameter int SH_U  = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [PW-1:0] in_prod,
  input  code_mode_e           in_mode,
  output logic [OUT_W-1:0]     word,
  output logic                 word_vld,
  output logic                 ovf_hi,
  output logic                 ovf_lo
);

  localparam int EW = PW + 1;
  localparam int SH_B = SH_U + 1;
  localparam logic signed [EW-1:0] ONE    = EW'(1);
  localparam logic signed [EW-1:0] HALF_U = ONE <<< (SH_U - 1);
  localparam logic signed [EW-1:0] HALF_B = ONE <<< (SH_B - 1);
  localparam logic signed [EW-1:0] MID    = ONE <<< (OUT_W - 1);
  localparam logic signed [EW-1:0] TOPV   = (ONE <<< OUT_W) - ONE;

  // Round to nearest (ties toward +inf) and scale, per coding.
  function automatic logic signed [EW-1:0] round_code(
    input logic signed [PW-1:0] p,
    input code_mode_e           m
  );
    logic signed [EW-1:0] pe;
    logic signed [EW-1:0] r;
    pe = EW'(p);
    if (m == CODE_BIP) begin
      r = ((pe + HALF_B) >>> SH_B) + MID;
    end else begin
      r = (pe + HALF_U) >>> SH_U;
    end
    return r;
  endfunction

  logic signed [EW-1:0] code_c;
  logic [OUT_W-1:0]     sat_c;

  assign code_c = round_code(in_prod, in_mode);
  assign ovf_hi = (code_c > TOPV);
  assign ovf_lo = (code_c < 0);

  always_comb begin
    if (ovf_hi) begin
      sat_c = '1;
    end else if (ovf_lo) begin
      sat_c = '0;
    end else begin
      sat_c = code_c[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= in_vld;
      if (in_vld) begin
        word <= sat_c;
      end
    end
  end

endmodule

// File: rtl/adc_word_fmt.sv
module adc_word_fmt
  import adc_fmt_pkg::*;
#(
  parameter int RAW_W     = 24,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 15,
  parameter int OUT_W     = 16,
  parameter int CYC_W     = 11,
  parameter int CONV_LEN  = 1624,
  parameter int MODE_LEAD = 82
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_vld,
  input  logic [RAW_W-1:0]  raw_data,
  input  logic [RAW_W-1:0]  ofs_coef,
  input  logic [GAIN_W-1:0] gain_coef,
  input  logic              code_bip,
  input  logic [CYC_W-1:0]  cyc_cnt,
  output logic [OUT_W-1:0]  word_out,
  output logic              word_vld
);

  localparam int PW      = RAW_W + GAIN_W + 2;
  localparam int SH_U    = GAIN_FRAC + RAW_W - 1 - OUT_W;
  localparam int SAMP_AT = CONV_LEN - MODE_LEAD;

  // Named internal events, observed by the bound checker.
  code_mode_e           mode_q;
  logic                 samp_hit;
  logic                 s1_vld;
  logic signed [PW-1:0] s1_prod;
  code_mode_e           s1_mode;
  logic                 ovf_hi;
  logic                 ovf_lo;

  fmt_mode_sampler #(
    .CYC_W   (CYC_W),
    .SAMP_AT (SAMP_AT)
  ) u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_cnt  (cyc_cnt),
    .code_bip (code_bip),
    .mode_q   (mode_q),
    .samp_hit (samp_hit)
  );

  fmt_scale_stage #(
    .RAW_W  (RAW_W),
    .GAIN_W (GAIN_W),
    .PW     (PW)
  ) u_scale (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (raw_vld),
    .raw      (raw_data),
    .ofs      (ofs_coef),
    .gain     (gain_coef),
    .in_mode  (mode_q),
    .out_vld  (s1_vld),
    .out_prod (s1_prod),
    .out_mode (s1_mode)
  );

  fmt_code_stage #(
    .PW    (PW),
    .OUT_W (OUT_W),
    .SH_U  (SH_U)
  ) u_code (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (s1_vld),
    .in_prod  (s1_prod),
    .in_mode  (s1_mode),
    .word     (word_out),
    .word_vld (word_vld),
    .ovf_hi   (ovf_hi),
    .ovf_lo   (ovf_lo)
  );

endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
  parameter int PW      = 42,
  parameter int OUT_W   = 16,
  parameter int CYC_W   = 11,
  parameter int SAMP_AT = 1542
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 raw_vld,
  input logic                 code_bip,
  input logic [CYC_W-1:0]     cyc_cnt,
  input logic                 mode_q,
  input logic                 s1_vld,
  input logic signed [PW-1:0] s1_prod,
  input logic                 s1_mode,
  input logic                 ovf_hi,
  input logic                 ovf_lo,
  input logic [OUT_W-1:0]     word_out,
  input logic                 word_vld
);

  localparam logic [OUT_W-1:0] MIDW = OUT_W'(1) << (OUT_W - 1);
  localparam logic [CYC_W-1:0] SAMP_CNT = CYC_W'(SAMP_AT);

  p_pipe_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    raw_vld |=> s1_vld);
  p_pipe_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> word_vld);
  p_pipe_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(s1_vld));
  p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> $stable(word_out));
  p_uni_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !s1_mode && s1_prod == '0) |=> word_out == '0);
  p_sat_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && ovf_hi) |=> word_out == '1);
  p_bip_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_mode && s1_prod == '0) |=> word_out == MIDW);
  p_sat_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && ovf_lo) |=> word_out == '0);
  p_mode_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_cnt != SAMP_CNT) |=> $stable(mode_q));
  p_mode_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_cnt == SAMP_CNT) |=> mode_q == $past(code_bip));

endmodule

bind adc_word_fmt fmt_checker #(
  .PW      (PW),
  .OUT_W   (OUT_W),
  .CYC_W   (CYC_W),
  .SAMP_AT (SAMP_AT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .raw_vld  (raw_vld),
  .code_bip (code_bip),
  .cyc_cnt  (cyc_cnt),
  .mode_q   (mode_q),
  .s1_vld   (s1_vld),
  .s1_prod  (s1_prod),
  .s1_mode  (s1_mode),
  .ovf_hi   (ovf_hi),
  .ovf_lo   (ovf_lo),
  .word_out (word_out),
  .word_vld (word_vld)
);

// File: tb/sim_adc_word_fmt.sv
module sim_adc_word_fmt;

  localparam int RAW_W     = 24;
  localparam int GAIN_W    = 16;
  localparam int GAIN_FRAC = 15;
  localparam int OUT_W     = 16;
  localparam int CYC_W     = 8;
  localparam int CONV_LEN  = 40;
  localparam int MODE_LEAD = 6;
  localparam int SAMP      = CONV_LEN - MODE_LEAD;
  localparam int SH        = GAIN_FRAC + RAW_W - 1 - OUT_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              raw_vld = 1'b0;
  logic [RAW_W-1:0]  raw_data = '0;
  logic [RAW_W-1:0]  ofs_coef = '0;
  logic [GAIN_W-1:0] gain_coef = '0;
  logic              code_bip = 1'b0;
  logic [CYC_W-1:0]  cyc_cnt = '0;
  logic [OUT_W-1:0]  word_out;
  logic              word_vld;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_word_fmt #(
    .RAW_W(RAW_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .OUT_W(OUT_W),
    .CYC_W(CYC_W), .CONV_LEN(CONV_LEN), .MODE_LEAD(MODE_LEAD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .raw_vld(raw_vld), .raw_data(raw_data),
    .ofs_coef(ofs_coef), .gain_coef(gain_coef), .code_bip(code_bip),
    .cyc_cnt(cyc_cnt), .word_out(word_out), .word_vld(word_vld)
  );

  // Reference: exact integer model, floor-based rounding, then clamp.
  function automatic longint ref_word(longint raw, longint ofs, longint gain, bit bip);
    longint p, dv, q, e;
    p  = (raw - ofs) * gain;
    dv = bip ? (longint'(1) << (SH + 1)) : (longint'(1) << SH);
    q  = p + dv / 2;
    if (q >= 0) e = q / dv;
    else        e = -((-q + dv - 1) / dv);
    if (bip) e = e + 32768;
    if (e > 65535) e = 65535;
    if (e < 0)     e = 0;
    return e;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One conversion: the coding is driven to the wanted value only in the capture cycle.
  task automatic conv(int raw, int ofs, int gain, bit bip, string req);
    longint exp;
    exp = ref_word(longint'(raw), longint'(ofs), longint'(gain), bip);
    for (int c = 0; c <= CONV_LEN + 1; c++) begin
      @(negedge clk);
      if (c == CONV_LEN - 1)
        check(word_vld == 1'b0, "R2 early", word_vld, 0);
      if (c == CONV_LEN) begin
        check(word_vld == 1'b1, "R2 strobe", word_vld, 1);
        check(word_out == exp[15:0], req, word_out, exp);
      end
      if (c == CONV_LEN + 1) begin
        check(word_vld == 1'b0, "R2 single", word_vld, 0);
        check(word_out == exp[15:0], "R9 hold", word_out, exp);
      end
      cyc_cnt   = CYC_W'(c);
      code_bip  = (c == SAMP) ? bip : ~bip;
      raw_vld   = (c == CONV_LEN - 2);
      raw_data  = RAW_W'(raw);
      ofs_coef  = RAW_W'(ofs);
      gain_coef = GAIN_W'(gain);
    end
  endtask

  initial begin
    int r, o, g;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(word_out == '0, "R1 word", word_out, 0);
    check(word_vld == 1'b0, "R1 vld", word_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(word_out == '0, "R1 word after release", word_out, 0);

    // Directed corners
    conv(1000, 1000, 32768, 0, "R3 zero uni");
    conv(1000, 1000, 32768, 1, "R5 zero bip mid");
    conv(64, 0, 32768, 0, "R3 half tie up");
    conv(-64, 0, 32768, 0, "R3 half tie neg");
    conv(-128, 0, 32768, 1, "R5 bip neg tie");
    conv(-129, 0, 32768, 1, "R5 bip below mid");
    conv(8388607, 0, 32768, 0, "R4 uni top");
    conv(8388607, -8388608, 65535, 0, "R4 uni over");
    conv(-8388608, 0, 32768, 0, "R4 uni under");
    conv(8388607, -8388608, 65535, 1, "R6 bip over");
    conv(-8388608, 8388607, 65535, 1, "R6 bip under");
    conv(-8388608, 0, 32768, 1, "R6 bip neg full");
    conv(4194304, 0, 32768, 1, "R5 bip pos half");
    // Same coefficients, alternating coding
    conv(3000000, 12345, 30000, 0, "R7 uni then");
    conv(3000000, 12345, 30000, 1, "R7 bip after");
    conv(3000000, 12345, 30000, 0, "R7 uni again");

    // Constrained random
    for (int i = 0; i < 200; i++) begin
      o = int'($urandom) >>> 16;
      g = int'($urandom_range(65535, 0));
      if (i % 3 == 0) r = int'($urandom) >>> 8;
      else r = o + (int'($urandom_range(32'h7F_FFFF, 0)) - 32'sh40_0000);
      if (r > 8388607) r = 8388607;
      if (r < -8388608) r = -8388608;
      conv(r, o, g, bit'($urandom_range(1, 0)), (i % 2) ? "R3/R5 random" : "R8 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule